// File: doc/BRIEF.md
# Program Status Polling Responder

This block forms the byte that a flash-style memory returns on a read while an internal program cycle is running. While the busy flag is high, two status indications are folded into the read data. Bit 7 carries the inverse of the stored bit 7 of the most recently loaded byte when that byte's address is read. Bit 6 flips on every new read access, whatever the address. The remaining bits echo the last loaded byte. Software can therefore detect the end of the cycle by either method. When busy is low, the array data passes through unchanged.

The surrounding controller decides when a cycle is busy. That includes the case where a write arrives without the unlock code: nothing is stored, but reads still behave as polling for the cycle time. The block captures each byte load (address and data), detects rising edges of the read strobe, and registers the composed read byte. It also produces a registered output-drive enable from the three active-low bus controls. All logic runs on one clock with a synchronous active-high reset.

Top module: `pstat_responder`

## Requirements
- R1: While reset is high, at the next clock edge `rd_data` becomes 0, `drive_en` becomes 0, the toggle state clears and the captured load clears to address 0, data 0.
- R2: When `busy` is low at a clock edge, `rd_data` after that edge equals `array_data` sampled at that edge.
- R3: A cycle with `load_valid` high stores `load_addr` and `load_data`, and later loads replace earlier ones. The stored pair is used from the following cycle onward.
- R4: When `busy` is high and `rd_addr` equals the stored load address, bit 7 of `rd_data` is the complement of bit 7 of the stored load byte.
- R5: When `busy` is high and `rd_addr` differs from the stored load address, bit 7 of `rd_data` equals bit 7 of the stored load byte.
- R6: During busy, bit 6 of `rd_data` shows a toggle state. The toggle is 0 at the first busy cycle and inverts on each rising edge of `rd_strobe` (strobe high after a low cycle), so the first read shows 1. Keeping the strobe high, or leaving it low, does not change it. The address has no effect.
- R7: During busy, bits 5 to 0 of `rd_data` equal the same bits of the stored load byte.
- R8: In the first cycle after `busy` falls, all eight bits of `rd_data` carry `array_data` again.
- R9: `drive_en` is 1 one cycle after a clock edge that sees `ce_n`=0, `oe_n`=0 and `we_n`=1. After any other combination it is 0.
- R10: Each new busy period restarts the toggle from 0. This holds even when a read edge coincides with the busy start, in which case that read shows 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal program or erase cycle in progress |
| load_valid | input | 1 | Byte load strobe, one cycle per byte |
| load_addr | input | 17 | Address of the loaded byte |
| load_data | input | 8 | Loaded byte value |
| rd_strobe | input | 1 | Read access strobe; a rising edge is one access |
| rd_addr | input | 17 | Read address |
| array_data | input | 8 | True stored data for the read address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_data | output | 8 | Registered read byte |
| drive_en | output | 1 | Registered output-drive enable; 0 means high impedance |

## Verification
Every result of this block appears exactly one clock edge after the inputs that cause it. That covers the read byte, both status bits and the drive enable. The toggle and the load capture affect the output from that same edge, because a load is only used one edge later. The bench drives inputs just after a falling edge. A behavioural model updates its expectations at the rising edge from those stable inputs. The outputs are compared at the next falling edge, so each comparison sees exactly one register stage.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

  // per-cycle events derived from the read strobe and busy flag
  typedef struct packed {
    logic busy;      // cycle in progress this clock
    logic start;     // first clock of a busy period
    logic rd_edge;   // new read access this clock
  } pstat_evt_t;

  // next toggle value for one clock
  function automatic logic toggle_step(input pstat_evt_t ev, input logic cur);
    logic nxt;
    if (ev.start)
      nxt = ev.rd_edge;
    else if (ev.busy && ev.rd_edge)
      nxt = ~cur;
    else
      nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/pstat_load_latch.sv
module pstat_load_latch #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (load_valid) begin
      last_addr <= load_addr;
      last_data <= load_data;
    end
  end

  // R3: a load is held until the next one
  a_r3_load_hold: assert property (@(posedge clk) disable iff (rst)
    !load_valid |=> $stable(last_data) && $stable(last_addr));

  a_r3_load_take: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> last_data == $past(load_data));

endmodule

// File: rtl/pstat_toggle.sv
module pstat_toggle
  import pstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       rd_strobe,
  output pstat_evt_t evt,
  output logic       tgl_nxt
);

  logic rd_q;
  logic busy_q;
  logic tgl_q;

  assign evt.busy    = busy;
  assign evt.start   = busy & ~busy_q;
  assign evt.rd_edge = rd_strobe & ~rd_q;

  always_comb tgl_nxt = toggle_step(evt, tgl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      rd_q   <= rd_strobe;
      busy_q <= busy;
      tgl_q  <= tgl_nxt;
    end
  end

  // R6: one flip per read edge inside a busy period
  a_r6_flip: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_q && rd_strobe && !rd_q) |=> tgl_q != $past(tgl_q));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && !rd_q) && !(busy && !busy_q) |=> $stable(tgl_q));

  // R10: busy start restarts the toggle
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && !busy_q && !rd_strobe) |=> !tgl_q);

endmodule

// File: rtl/pstat_out_mux.sv
module pstat_out_mux #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              tgl_nxt,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [DATA_W-1:0] last_data,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data
);

  logic              hit;
  logic [DATA_W-1:0] mux_d;

  assign hit = (rd_addr == last_addr);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign mux_d[i] = busy ? (last_data[i] ^ hit) : array_data[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign mux_d[i] = busy ? tgl_nxt : array_data[i];
    end else begin : g_echo
      assign mux_d[i] = busy ? last_data[i] : array_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux_d;
  end

  // R2: idle reads pass the array byte through
  a_r2_idle_pass: assert property (@(posedge clk) disable iff (rst)
    !busy |=> rd_data == $past(array_data));

  // R4: polled bit inverted at the last loaded address
  a_r4_poll_inv: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_addr == last_addr) |=> rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT]));

  // R5: polled bit true elsewhere
  a_r5_poll_true: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_addr != last_addr) |=> rd_data[POLL_BIT] == $past(last_data[POLL_BIT]));

endmodule

// File: rtl/pstat_drive.sv
module pstat_drive (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic drive_en
);

  always_ff @(posedge clk) begin
    if (rst) drive_en <= 1'b0;
    else     drive_en <= ~ce_n & ~oe_n & we_n;
  end

  // R9: any deselecting control floats the outputs
  a_r9_float: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !we_n) |=> !drive_en);

  a_r9_drive: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> drive_en);

endmodule

// File: rtl/pstat_responder.sv
module pstat_responder #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = DATA_W - 1,
  parameter int TOGGLE_BIT = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              load_valid,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              drive_en
);
  import pstat_pkg::*;

  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  pstat_evt_t        evt;
  logic              tgl_nxt;

  pstat_load_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_load (
    .clk(clk), .rst(rst), .load_valid(load_valid),
    .load_addr(load_addr), .load_data(load_data),
    .last_addr(last_addr), .last_data(last_data)
  );

  pstat_toggle u_tog (
    .clk(clk), .rst(rst), .busy(busy), .rd_strobe(rd_strobe),
    .evt(evt), .tgl_nxt(tgl_nxt)
  );

  pstat_out_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_mux (
    .clk(clk), .rst(rst), .busy(evt.busy), .tgl_nxt(tgl_nxt),
    .rd_addr(rd_addr), .last_addr(last_addr), .last_data(last_data),
    .array_data(array_data), .rd_data(rd_data)
  );

  pstat_drive u_drv (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .drive_en(drive_en)
  );

  // R1: outputs cleared by reset
  a_r1_reset: assert property (@(posedge clk)
    rst |=> rd_data == '0 && !drive_en);

  // R8: leaving busy restores the whole array byte
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> rd_data == $past(array_data));

endmodule

// File: tb/pstat_responder_test.sv
`timescale 1ns/1ps
module pstat_responder_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        busy, load_valid, rd_strobe, ce_n, oe_n, we_n;
  logic [16:0] load_addr, rd_addr;
  logic [7:0]  load_data, array_data;
  logic [7:0]  rd_data;
  logic        drive_en;

  always #10 clk = ~clk;

  pstat_responder uut (
    .clk(clk), .rst(rst), .busy(busy), .load_valid(load_valid),
    .load_addr(load_addr), .load_data(load_data), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .array_data(array_data), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .rd_data(rd_data), .drive_en(drive_en)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int periods = 0;
  bit armed = 0;

  // reference model state
  logic [7:0]  exp_data;
  logic        exp_drv;
  logic        m_tgl, m_rdq, m_busyq;
  logic [16:0] m_la;
  logic [7:0]  m_ld;
  string       tag7, tag6, tag_lo;
  bit          was_reset;

  always @(posedge clk) begin
    logic rd_new, first;
    cycles++;
    if (rst) begin
      exp_data = 8'h00; exp_drv = 1'b0;
      m_tgl = 0; m_rdq = 0; m_busyq = 0; m_la = '0; m_ld = '0;
      was_reset = 1; periods = 0;
    end else begin
      was_reset = 0;
      rd_new = rd_strobe && !m_rdq;
      first  = busy && !m_busyq;
      if (first) begin
        periods++;
        m_tgl = rd_new;
      end else if (busy && rd_new) begin
        m_tgl = !m_tgl;
      end
      if (busy) begin
        exp_data = m_ld;
        if (rd_addr == m_la) begin exp_data[7] = ~m_ld[7]; tag7 = "R4"; end
        else                 begin tag7 = "R5"; end
        exp_data[6] = m_tgl;
        tag6   = (periods > 1) ? "R10" : "R6";
        tag_lo = "R3/R7";
      end else begin
        exp_data = array_data;
        tag7 = m_busyq ? "R8" : "R2";
        tag6 = tag7; tag_lo = tag7;
      end
      exp_drv = !ce_n && !oe_n && we_n;
      if (load_valid) begin m_la = load_addr; m_ld = load_data; end
      m_rdq = rd_strobe; m_busyq = busy;
    end
    armed = 1;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  // compare at every falling edge, before new inputs are driven
  task automatic step();
    @(negedge clk);
    if (armed) begin
      if (was_reset) begin
        chk("R1", rd_data, 8'h00);
        chk("R1", {7'd0, drive_en}, 8'h00);
      end else begin
        chk(tag7,   {7'd0, rd_data[7]}, {7'd0, exp_data[7]});
        chk(tag6,   {7'd0, rd_data[6]}, {7'd0, exp_data[6]});
        chk(tag_lo, {2'd0, rd_data[5:0]}, {2'd0, exp_data[5:0]});
        chk("R9",   {7'd0, drive_en}, {7'd0, exp_drv});
      end
    end
  endtask

  task automatic rd(input logic [16:0] a, input logic [7:0] arr);
    rd_addr = a; array_data = arr; rd_strobe = 1; ce_n = 0; oe_n = 0; we_n = 1;
    step();
    rd_strobe = 0; oe_n = 1;
    step();
  endtask

  task automatic ld(input logic [16:0] a, input logic [7:0] d);
    load_valid = 1; load_addr = a; load_data = d; we_n = 0; ce_n = 0; oe_n = 1;
    step();
    load_valid = 0; we_n = 1;
  endtask

  initial begin
    rst = 1; busy = 0; load_valid = 0; rd_strobe = 0; ce_n = 1; oe_n = 1; we_n = 1;
    load_addr = '0; load_data = '0; rd_addr = '0; array_data = 8'h5A;
    repeat (3) step();                                  // R1
    rst = 0;
    // R2 / R9: idle pass-through, bus control combinations
    rd(17'h00010, 8'hC3);
    rd(17'h1FFFF, 8'h3C);
    ce_n = 1; oe_n = 0; we_n = 1; step();
    ce_n = 0; oe_n = 0; we_n = 0; step();
    // R3: several loads, last wins
    ld(17'h00123, 8'h11);
    ld(17'h00456, 8'hA5);
    step();
    // R4/R5/R6/R7 first busy period
    busy = 1; step();
    rd(17'h00456, 8'h00);                               // hit, R4
    rd(17'h00100, 8'hFF);                               // miss, R5
    rd_addr = 17'h00456; rd_strobe = 1; ce_n = 0; oe_n = 0;
    repeat (4) step();                                  // R6 held high
    rd_strobe = 0; step();
    rd(17'h00456, 8'h77);
    ld(17'h00200, 8'h4E);                               // load while busy
    rd(17'h00200, 8'h00);
    rd(17'h00201, 8'h00);
    // R8: release
    busy = 0; rd_addr = 17'h00200; array_data = 8'h96; step();
    rd(17'h00200, 8'h69);
    // R10: second period with read edge at busy start
    ld(17'h1F000, 8'hF0);
    step();
    busy = 1; rd_addr = 17'h1F000; rd_strobe = 1; ce_n = 0; oe_n = 0; step();
    rd_strobe = 0; step();
    rd(17'h1F000, 8'h00);
    rd(17'h00000, 8'h00);
    busy = 0; step();
    // third period, no read at start
    step();
    busy = 1; step(); step();
    rd(17'h1F000, 8'h00);
    busy = 0; array_data = 8'h00; step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule